// File: doc/BRIEF.md
# External Memory Port Controller with Bus Hand-Off

This block sits between a small processor core and its external memory port. For each external access the core requests, it drives one of two active-low space selects (program or data). It drives an active-low bank select for the Y data bank, and in development mode also for exception-vector fetches. It also drives read and write strobes, the address and the write data. An active-low bus-select strobe marks every external access and stays low for as long as the external wait input holds the access open.

An outside master can claim the port through an active-low request and grant pair. The request passes through a two-stage synchroniser. The port is handed over only when the core signals an instruction boundary and no access is in flight. While the port is released, a drive-enable output tells the pads to float the selects, strobes, address and data, and bus-select is held high. The core keeps running: only its external requests are stalled. When the request is withdrawn, grant is removed first and the port is driven again one cycle later.

Top module: `ext_port_ctl`

## Requirements
- R1: While reset is low, ext_grant_n is 1, drive_en is 0 and bsel_n is 1, whatever ext_req_n does.
- R2: An accepted request with core_space=0 (program) drives prog_sel_n low and data_sel_n high, starting the cycle after acceptance. An accepted request with core_space=1 (data) does the opposite. addr_out carries the requested address.
- R3: For a data access, bank_sel_n is low exactly when core_bank=1 (Y bank).
- R4: When core_vec=1 and dev_mode=1, bank_sel_n is also low, whatever the space. With dev_mode=0 a vector fetch leaves it high.
- R5: bsel_n is low exactly during access cycles. rd_n is low for reads (core_wr=0) and wr_n is low for writes. data_oe is 1 only during write accesses, with data_out equal to the write data.
- R6: Each cycle of an access in which wait_in is 1 extends the access by one cycle. core_ack is 1 in the access cycle where wait_in is 0, and the strobes return high one cycle later. An access with N wait cycles holds bsel_n low for N+1 cycles.
- R7: After ext_req_n falls, ext_grant_n falls three rising edges later at the earliest: two edges for synchronisation and one for the state change. This happens only in an idle cycle with insn_end=1. While insn_end is 0, the grant is withheld and core accesses still proceed.
- R8: While ext_grant_n is 0, drive_en is 0 and bsel_n is 1, no strobe is asserted, and a core request sees core_stall=1.
- R9: After ext_req_n rises, ext_grant_n rises three rising edges later. drive_en returns to 1 one edge after that.
- R10: An access already under way when the request arrives runs to its end before the grant is given.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_req | input | 1 | Core requests an external access; held until core_ack |
| core_space | input | 1 | 0 = program space, 1 = data space |
| core_bank | input | 1 | Data bank: 0 = X, 1 = Y |
| core_wr | input | 1 | 1 = write, 0 = read |
| core_vec | input | 1 | Access is an exception-vector fetch |
| dev_mode | input | 1 | Development mode flag |
| insn_end | input | 1 | Current instruction completes this cycle |
| core_addr | input | AW | Access address |
| core_wdata | input | DW | Write data |
| wait_in | input | 1 | External wait, sampled while bsel_n is low |
| ext_req_n | input | 1 | Asynchronous active-low bus request from an outside master |
| prog_sel_n | output | 1 | Program space select, active low |
| data_sel_n | output | 1 | Data space select, active low |
| bank_sel_n | output | 1 | Y-bank / vector select, active low |
| bsel_n | output | 1 | Bus-select strobe, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| addr_out | output | AW | Address bus value |
| data_out | output | DW | Write data bus value |
| data_oe | output | 1 | Data bus drive enable |
| drive_en | output | 1 | Pad enable for selects, strobes and address; 0 means float |
| ext_grant_n | output | 1 | Bus grant, active low |
| core_ack | output | 1 | Access completes this cycle |
| core_stall | output | 1 | Core request not completed this cycle |

## Verification
The hardest case to reach is a bus request that arrives in the middle of a wait-extended access. The grant must stay off through every remaining wait cycle, with insn_end held high, and appear only after the access ends. The bench starts a long access and lowers the request in the same cycle. It checks the grant on every wait cycle and then counts the edges until the grant appears. The sweep over space, bank, direction, vector flag, mode and wait count covers the select decoding. A separate phase withholds insn_end to show that the hand-off waits for the instruction boundary.

// File: rtl/ext_port_ctl.sv
module ext_port_ctl #(
  parameter int AW = 16,
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          core_req,
  input  logic          core_space,
  input  logic          core_bank,
  input  logic          core_wr,
  input  logic          core_vec,
  input  logic          dev_mode,
  input  logic          insn_end,
  input  logic [AW-1:0] core_addr,
  input  logic [DW-1:0] core_wdata,
  input  logic          wait_in,
  input  logic          ext_req_n,
  output logic          prog_sel_n,
  output logic          data_sel_n,
  output logic          bank_sel_n,
  output logic          bsel_n,
  output logic          rd_n,
  output logic          wr_n,
  output logic [AW-1:0] addr_out,
  output logic [DW-1:0] data_out,
  output logic          data_oe,
  output logic          drive_en,
  output logic          ext_grant_n,
  output logic          core_ack,
  output logic          core_stall
);
  typedef enum logic [1:0] {S_IDLE, S_ACC, S_GRANT, S_REDRIVE} state_t;

  state_t        state;
  logic          req_s1, req_s2;
  logic          l_space, l_bank, l_wr, l_vsel;
  logic [AW-1:0] l_addr;
  logic [DW-1:0] l_data;

  wire in_acc   = (state == S_ACC);
  wire release_ok = req_s2 && insn_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_s1 <= 1'b0;
      req_s2 <= 1'b0;
    end else begin
      req_s1 <= ~ext_req_n;
      req_s2 <= req_s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      l_space <= 1'b0;
      l_bank  <= 1'b0;
      l_wr    <= 1'b0;
      l_vsel  <= 1'b0;
      l_addr  <= '0;
      l_data  <= '0;
    end else begin
      case (state)
        S_IDLE:
          if (release_ok) state <= S_GRANT;
          else if (core_req) begin
            state   <= S_ACC;
            l_space <= core_space;
            l_bank  <= core_bank;
            l_wr    <= core_wr;
            l_vsel  <= core_vec && dev_mode;
            l_addr  <= core_addr;
            l_data  <= core_wdata;
          end
        S_ACC:     if (!wait_in) state <= S_IDLE;
        S_GRANT:   if (!req_s2) state <= S_REDRIVE;
        S_REDRIVE: state <= S_IDLE;
        default:   state <= S_IDLE;
      endcase
    end
  end

  assign drive_en    = rst_n && (state == S_IDLE || state == S_ACC);
  assign ext_grant_n = ~(rst_n && state == S_GRANT);
  assign bsel_n      = ~(rst_n && in_acc);
  assign prog_sel_n  = ~(in_acc && !l_space);
  assign data_sel_n  = ~(in_acc && l_space);
  assign bank_sel_n  = ~(in_acc && ((l_space && l_bank) || l_vsel));
  assign rd_n        = ~(in_acc && !l_wr);
  assign wr_n        = ~(in_acc && l_wr);
  assign data_oe     = drive_en && in_acc && l_wr;
  assign addr_out    = l_addr;
  assign data_out    = l_data;
  assign core_ack    = in_acc && !wait_in;
  assign core_stall  = core_req && !core_ack;
endmodule

module ext_port_ctl_chk #(
  parameter int AW = 16,
  parameter int DW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wait_in,
  input logic          prog_sel_n,
  input logic          data_sel_n,
  input logic          bsel_n,
  input logic [AW-1:0] addr_out,
  input logic          drive_en,
  input logic          ext_grant_n
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (ext_grant_n && !drive_en && bsel_n));

  a_r2_one_space: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({~prog_sel_n, ~data_sel_n}));

  a_r5_sel_in_access: assert property (@(posedge clk) disable iff (!rst_n)
    (!prog_sel_n || !data_sel_n) |-> !bsel_n);

  a_r6_wait_extends: assert property (@(posedge clk) disable iff (!rst_n)
    (!bsel_n && wait_in) |=> (!bsel_n && $stable(addr_out)));

  a_r8_granted_floats: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_grant_n |-> (!drive_en && bsel_n));

  a_r9_redrive_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_grant_n) |-> !drive_en);

  a_r10_no_grant_in_access: assert property (@(posedge clk) disable iff (!rst_n)
    !bsel_n |-> ext_grant_n);
endmodule

bind ext_port_ctl ext_port_ctl_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wait_in(wait_in), .prog_sel_n(prog_sel_n),
  .data_sel_n(data_sel_n), .bsel_n(bsel_n), .addr_out(addr_out),
  .drive_en(drive_en), .ext_grant_n(ext_grant_n)
);

// File: tb/ext_port_ctl_test.sv
module ext_port_ctl_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic core_req = 0, core_space = 0, core_bank = 0, core_wr = 0, core_vec = 0;
  logic dev_mode = 0, insn_end = 0, wait_in = 0, ext_req_n = 1;
  logic [AW-1:0] core_addr = '0;
  logic [DW-1:0] core_wdata = '0;
  logic prog_sel_n, data_sel_n, bank_sel_n, bsel_n, rd_n, wr_n;
  logic [AW-1:0] addr_out;
  logic [DW-1:0] data_out;
  logic data_oe, drive_en, ext_grant_n, core_ack, core_stall;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ext_port_ctl #(.AW(AW), .DW(DW)) uut (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic access(input logic sp, input logic bk, input logic wr, input logic vec,
                        input logic dm, input int nwait, input logic [AW-1:0] a);
    logic exp_bank;
    core_req = 1; core_space = sp; core_bank = bk; core_wr = wr; core_vec = vec;
    dev_mode = dm; core_addr = a; core_wdata = {8'h5A, a};
    tick();
    exp_bank = !((sp && bk) || (vec && dm));
    for (int k = 0; k <= nwait; k++) begin
      wait_in = (k < nwait);
      #1;
      check("R2 prog_sel_n", prog_sel_n, sp);
      check("R2 data_sel_n", data_sel_n, !sp);
      check("R2 addr_out", addr_out, a);
      check("R3/R4 bank_sel_n", bank_sel_n, exp_bank);
      check("R5 bsel_n", bsel_n, 0);
      check("R5 rd_n", rd_n, wr);
      check("R5 wr_n", wr_n, !wr);
      check("R5 data_oe", data_oe, wr);
      if (wr) check("R5 data_out", data_out, {8'h5A, a});
      check("R6 core_ack", core_ack, (k == nwait));
      check("R10 grant held", ext_grant_n, 1);
      if (k == nwait) core_req = 0;
      tick();
    end
    wait_in = 0;
    check("R6 strobes released", {bsel_n, prog_sel_n, data_sel_n}, 3'b111);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    ext_req_n = 0;
    repeat (4) tick();
    check("R1 grant in reset", ext_grant_n, 1);
    check("R1 drive_en in reset", drive_en, 0);
    check("R1 bsel_n in reset", bsel_n, 1);
    ext_req_n = 1;
    tick();
    rst_n = 1;
    tick();
    check("R1 driven after reset", drive_en, 1);

    for (int m = 0; m < 64; m++)
      access(m[0], m[1], m[2], m[3], m[4], m[5] ? 2 : 0, AW'(16'h1000 + m * 7));
    for (int w = 0; w < 5; w++) access(1, 1, 0, 0, 0, w, AW'(16'h2000 + w));

    // R7: no release without instruction boundary; accesses continue
    insn_end = 0;
    ext_req_n = 0;
    repeat (6) tick();
    check("R7 grant withheld", ext_grant_n, 1);
    access(0, 0, 1, 0, 0, 1, 16'h3333);
    check("R7 still withheld", ext_grant_n, 1);
    insn_end = 1;
    tick();
    check("R7 grant at boundary", ext_grant_n, 0);

    // R8
    core_req = 1; core_space = 1;
    #1;
    check("R8 stall", core_stall, 1);
    check("R8 drive_en", drive_en, 0);
    repeat (3) tick();
    check("R8 bsel_n", bsel_n, 1);
    check("R8 data_sel_n", data_sel_n, 1);
    check("R8 drive_en held", drive_en, 0);

    // R9
    ext_req_n = 1;
    tick(); tick();
    check("R9 grant after 2 edges", ext_grant_n, 0);
    tick();
    check("R9 grant released", ext_grant_n, 1);
    check("R9 gap", drive_en, 0);
    core_req = 0;
    tick();
    check("R9 redriven", drive_en, 1);

    // R7 latency from idle with boundary
    ext_req_n = 0;
    tick(); tick();
    check("R7 not yet", ext_grant_n, 1);
    tick();
    check("R7 three edges", ext_grant_n, 0);
    ext_req_n = 1;
    repeat (4) tick();
    check("R9 back to master", drive_en, 1);

    // R10: request lands during long access
    core_req = 1; core_space = 0; core_bank = 0; core_wr = 0; core_vec = 0;
    core_addr = 16'h4444; ext_req_n = 0;
    tick();
    for (int k = 0; k < 6; k++) begin
      wait_in = (k < 5);
      #1;
      check("R10 bsel_n low", bsel_n, 0);
      check("R10 grant held", ext_grant_n, 1);
      if (k == 5) core_req = 0;
      tick();
    end
    wait_in = 0;
    check("R10 access ended", bsel_n, 1);
    tick();
    check("R10 grant after access", ext_grant_n, 0);
    ext_req_n = 1;
    repeat (5) tick();
    check("R9 final redrive", drive_en, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule